// File: doc/BRIEF.md
# Structure Access Address and Base Writeback Unit

This unit sits beside the load/store pipeline of a vector register file and handles the address side of a multi-register structure transfer. When a request is accepted it captures the base address, the offset register value, the writeback mode, the alignment hint, the register count and the element size. One cycle later it presents the access start address, which is always the unmodified base. In the same cycle it reports whether the encoding is illegal and whether the address breaks the alignment rule.

If the request is clean, the unit waits until the memory sequencer signals that every beat of the transfer has finished. In the cycle after that signal it pulses `done`. When a writeback mode is selected, it drives the new base value and a one-cycle write enable together with `done`. There are three writeback modes: none, base plus the number of bytes moved (8 bytes per register), and base plus an offset register. The sum wraps modulo 2^32.

A request that faults or is illegal produces no writeback and no `done`, and the unit returns to idle at once.

Top module: `struct_addr_wb`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every output is 0.
- R2: A request is accepted only when the unit is idle. One cycle after acceptance, `acc_valid` pulses for one cycle and `acc_addr` equals the captured base, whatever the writeback mode. `acc_addr` is 0 when `acc_valid` is low.
- R3: With `wb_mode`=01, `wb_value` equals the base plus 8 times `reg_cnt`, modulo 2^32.
- R4: With `wb_mode`=10, `wb_value` equals the base plus `off_val`, modulo 2^32.
- R5: With `wb_mode`=00, `done` pulses without `wb_en`. `wb_value` is 0 whenever `wb_en` is low.
- R6: For a clean request, `done` (and `wb_en` when a writeback mode is selected) rises in the cycle after the first cycle in which the unit is busy and `xfer_done` is high. It stays high for one cycle only.
- R7: The hint field `align_hint` uses 00 for none, 01 for 8 bytes, 10 for 16 bytes and 11 for 32 bytes. With `reg_cnt` of 1 or 3, only 00 and 01 are legal. With 2, the values 00 to 10 are legal. With 4, every value is legal. A hint outside these sets raises `illegal` together with `acc_valid`.
- R8: With a hint other than 00, a base that is not a multiple of the hinted byte count raises `align_fault` together with `acc_valid`.
- R9: With hint 00, the base must be a multiple of 2^`elem_log2` bytes. Otherwise `align_fault` is raised.
- R10: `illegal` is raised in any of these cases: `base_idx` is 15; `wb_mode` is 10 and `off_idx` is 13 or 15; `wb_mode` is 11; `reg_cnt` is outside 1 to 4. `off_idx` is ignored in the other modes.
- R11: After `illegal` or `align_fault`, the unit is idle again. Neither `done` nor `wb_en` follows, even if `xfer_done` is pulsed.
- R12: `req_valid` while busy and `xfer_done` while idle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New transfer request |
| base_val | input | 32 | Base register contents |
| off_val | input | 32 | Offset register contents |
| base_idx | input | 4 | Index of the base register |
| off_idx | input | 4 | Index of the offset register |
| wb_mode | input | 2 | 00 none, 01 by byte count, 10 by offset, 11 illegal |
| align_hint | input | 2 | 00 none, 01 8 B, 10 16 B, 11 32 B |
| reg_cnt | input | 3 | Number of 64-bit registers, 1 to 4 |
| elem_log2 | input | 2 | log2 of element size in bytes |
| xfer_done | input | 1 | All beats of the transfer have finished |
| acc_valid | output | 1 | Start address is valid (one cycle) |
| acc_addr | output | 32 | Access start address |
| align_fault | output | 1 | Alignment violation |
| illegal | output | 1 | Illegal encoding |
| done | output | 1 | Instruction finished |
| wb_en | output | 1 | Base register write enable |
| wb_value | output | 32 | Updated base value |

## Verification
Two functions can fall in the same cycle. The writeback of one instruction lands in the cycle when the unit has already returned to idle, so a new request can be accepted in exactly the cycle that `done` and `wb_en` are high. The bench provokes this by raising `req_valid` in the cycle after `xfer_done`. It then expects the old writeback and the new start address in consecutive cycles, with neither one lost. A second overlap occurs when one encoding is both illegal and misaligned: both flags must rise together with `acc_valid`, and no writeback may follow.

// File: rtl/struct_addr_pkg.sv
package struct_addr_pkg;
  localparam int ADDR_W = 32;
  localparam int IDX_W = 4;
  localparam int CNT_W = 3;
  localparam int MAX_REGS = 4;
  localparam int REG_BYTES = 8;
  localparam logic [IDX_W-1:0] IDX_PC = 4'd15;
  localparam logic [IDX_W-1:0] IDX_SP = 4'd13;

  typedef enum logic [1:0] {
    WB_NONE  = 2'b00,
    WB_BYTES = 2'b01,
    WB_OFFS  = 2'b10,
    WB_BAD   = 2'b11
  } wb_mode_e;

  typedef enum logic [1:0] {
    HINT_NONE = 2'b00,
    HINT_8    = 2'b01,
    HINT_16   = 2'b10,
    HINT_32   = 2'b11
  } hint_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } state_e;
endpackage

// File: rtl/struct_addr_legal.sv
module struct_addr_legal
  import struct_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W,
  parameter int CW = CNT_W,
  parameter int NREGS = MAX_REGS
) (
  input  logic [AW-1:0] base_val,
  input  logic [IW-1:0] base_idx,
  input  logic [IW-1:0] off_idx,
  input  logic [1:0]    wb_mode,
  input  logic [1:0]    align_hint,
  input  logic [CW-1:0] reg_cnt,
  output logic          illegal
);
  logic idx_bad, cnt_bad, hint_bad;
  logic unused_base;

  assign unused_base = ^base_val;

  always_comb begin
    idx_bad = (base_idx == IDX_PC);
    if (wb_mode == WB_OFFS)
      idx_bad = idx_bad || (off_idx == IDX_SP) || (off_idx == IDX_PC);
    if (wb_mode == WB_BAD)
      idx_bad = 1'b1;
  end

  assign cnt_bad = (reg_cnt == '0) || (reg_cnt > CW'(NREGS));

  always_comb begin
    case (reg_cnt)
      CW'(2):  hint_bad = (align_hint == HINT_32);
      CW'(4):  hint_bad = 1'b0;
      default: hint_bad = (align_hint == HINT_16) || (align_hint == HINT_32);
    endcase
  end

  assign illegal = idx_bad || cnt_bad || hint_bad;
endmodule

// File: rtl/struct_addr_align.sv
module struct_addr_align
  import struct_addr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] base_val,
  input  logic [1:0]    align_hint,
  input  logic [1:0]    elem_log2,
  output logic          fault
);
  localparam int LOWB = 5;
  logic [LOWB-1:0] mask;

  always_comb begin
    if (align_hint == HINT_NONE)
      mask = LOWB'((1 << elem_log2) - 1);
    else
      mask = LOWB'((1 << (32'(align_hint) + 2)) - 1);
  end

  assign fault = |(base_val[LOWB-1:0] & mask);
endmodule

// File: rtl/struct_addr_next.sv
module struct_addr_next
  import struct_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W,
  parameter int RB = REG_BYTES
) (
  input  logic [AW-1:0] base_q,
  input  logic [AW-1:0] off_q,
  input  logic [CW-1:0] cnt_q,
  input  logic [1:0]    mode_q,
  output logic          wr,
  output logic [AW-1:0] next_base
);
  logic [AW-1:0] byte_total;
  assign byte_total = AW'(cnt_q) * AW'(RB);

  always_comb begin
    wr = 1'b1;
    unique case (mode_q)
      WB_BYTES: next_base = base_q + byte_total;
      WB_OFFS:  next_base = base_q + off_q;
      default: begin
        wr = 1'b0;
        next_base = '0;
      end
    endcase
  end
endmodule

// File: rtl/struct_addr_wb.sv
module struct_addr_wb
  import struct_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W,
  parameter int CW = CNT_W,
  parameter int NREGS = MAX_REGS,
  parameter int RB = REG_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] off_val,
  input  logic [IW-1:0] base_idx,
  input  logic [IW-1:0] off_idx,
  input  logic [1:0]    wb_mode,
  input  logic [1:0]    align_hint,
  input  logic [CW-1:0] reg_cnt,
  input  logic [1:0]    elem_log2,
  input  logic          xfer_done,
  output logic          acc_valid,
  output logic [AW-1:0] acc_addr,
  output logic          align_fault,
  output logic          illegal,
  output logic          done,
  output logic          wb_en,
  output logic [AW-1:0] wb_value
);
  state_e        state;
  logic [AW-1:0] base_q, off_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    mode_q;
  logic          ill_c, flt_c, wr_c;
  logic [AW-1:0] next_c;
  logic          accept;

  assign accept = req_valid && (state == ST_IDLE);

  struct_addr_legal #(.AW(AW), .IW(IW), .CW(CW), .NREGS(NREGS)) u_legal (
    .base_val(base_val), .base_idx(base_idx), .off_idx(off_idx),
    .wb_mode(wb_mode), .align_hint(align_hint), .reg_cnt(reg_cnt),
    .illegal(ill_c)
  );

  struct_addr_align #(.AW(AW)) u_align (
    .base_val(base_val), .align_hint(align_hint), .elem_log2(elem_log2),
    .fault(flt_c)
  );

  struct_addr_next #(.AW(AW), .CW(CW), .RB(RB)) u_next (
    .base_q(base_q), .off_q(off_q), .cnt_q(cnt_q), .mode_q(mode_q),
    .wr(wr_c), .next_base(next_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      base_q      <= '0;
      off_q       <= '0;
      cnt_q       <= '0;
      mode_q      <= WB_NONE;
      acc_valid   <= 1'b0;
      acc_addr    <= '0;
      align_fault <= 1'b0;
      illegal     <= 1'b0;
      done        <= 1'b0;
      wb_en       <= 1'b0;
      wb_value    <= '0;
    end else begin
      acc_valid   <= 1'b0;
      acc_addr    <= '0;
      align_fault <= 1'b0;
      illegal     <= 1'b0;
      done        <= 1'b0;
      wb_en       <= 1'b0;
      wb_value    <= '0;
      if (accept) begin
        base_q      <= base_val;
        off_q       <= off_val;
        cnt_q       <= reg_cnt;
        mode_q      <= wb_mode;
        acc_valid   <= 1'b1;
        acc_addr    <= base_val;
        align_fault <= flt_c;
        illegal     <= ill_c;
        state       <= (ill_c || flt_c) ? ST_IDLE : ST_BUSY;
      end else if (state == ST_BUSY && xfer_done) begin
        done     <= 1'b1;
        wb_en    <= wr_c;
        wb_value <= next_c;
        state    <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/struct_addr_wb_sva.sv
module struct_addr_wb_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic          align_fault,
  input logic          illegal,
  input logic          done,
  input logic          wb_en,
  input logic [AW-1:0] wb_value
);
  // R5: write enable only together with done
  p_wb_with_done_r5: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done);
  // R5: wb_value quiet without wb_en
  p_wbval_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !wb_en |-> (wb_value == '0));
  // R7 / R8: flags accompany the address pulse
  p_flags_need_acc_r8: assert property (@(posedge clk) disable iff (rst)
    (align_fault || illegal) |-> acc_valid);
  // R11: a rejected request is never followed by done
  p_no_done_after_fault_r11: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && (align_fault || illegal)) |=> !done);
  // R2 / R6: address pulse and done never share a cycle
  p_acc_done_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_valid, done}));
  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind struct_addr_wb struct_addr_wb_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .align_fault(align_fault),
  .illegal(illegal), .done(done), .wb_en(wb_en), .wb_value(wb_value)
);

// File: tb/struct_addr_wb_test.sv
module struct_addr_wb_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic [31:0] base_val = 0, off_val = 0;
  logic [3:0]  base_idx = 0, off_idx = 0;
  logic [1:0]  wb_mode = 0, align_hint = 0, elem_log2 = 0;
  logic [2:0]  reg_cnt = 1;
  logic        xfer_done = 0;
  logic        acc_valid, align_fault, illegal, done, wb_en;
  logic [31:0] acc_addr, wb_value;

  int vectors = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  struct_addr_wb uut (.*);

  // behavioural reference state
  int          m_busy = 0;
  logic [31:0] m_base, m_off;
  int          m_mode, m_cnt;
  logic        e_acc, e_flt, e_ill, e_done, e_wb;
  logic [31:0] e_addr, e_val;

  function automatic logic ref_illegal(int bi, int oi, int md, int hn, int cn);
    if (bi == 15) return 1;
    if (md == 3) return 1;
    if (md == 2 && (oi == 13 || oi == 15)) return 1;
    if (cn < 1 || cn > 4) return 1;
    if (hn == 3 && cn != 4) return 1;
    if (hn == 2 && (cn == 1 || cn == 3)) return 1;
    return 0;
  endfunction

  function automatic logic ref_fault(logic [31:0] a, int hn, int es);
    int bytes;
    bytes = (hn == 0) ? (1 << es) : (4 << hn);
    return (a % bytes) != 0;
  endfunction

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      e_acc = 0; e_flt = 0; e_ill = 0; e_done = 0; e_wb = 0; e_addr = 0; e_val = 0;
      m_busy = 0;
    end else begin
      e_acc = 0; e_flt = 0; e_ill = 0; e_done = 0; e_wb = 0; e_addr = 0; e_val = 0;
      if (m_busy == 0 && req_valid) begin
        e_acc = 1; e_addr = base_val;
        e_ill = ref_illegal(base_idx, off_idx, wb_mode, align_hint, reg_cnt);
        e_flt = ref_fault(base_val, align_hint, elem_log2);
        m_base = base_val; m_off = off_val; m_mode = wb_mode; m_cnt = reg_cnt;
        m_busy = (e_ill || e_flt) ? 0 : 1;
      end else if (m_busy == 1 && xfer_done) begin
        e_done = 1;
        if (m_mode == 1) begin e_wb = 1; e_val = m_base + 32'(m_cnt * 8); end
        if (m_mode == 2) begin e_wb = 1; e_val = m_base + m_off; end
        m_busy = 0;
      end
    end
    #1;
    if (!rst) begin
      cmp("R2 acc_valid", 32'(acc_valid), 32'(e_acc));
      cmp("R2 acc_addr", acc_addr, e_addr);
      cmp("R7/R10 illegal", 32'(illegal), 32'(e_ill));
      cmp("R8/R9 align_fault", 32'(align_fault), 32'(e_flt));
      cmp("R6/R11 done", 32'(done), 32'(e_done));
      cmp("R5 wb_en", 32'(wb_en), 32'(e_wb));
      cmp("R3 or R4 wb_value", wb_value, e_val);
    end
  end

  task automatic req(logic [31:0] b, logic [31:0] o, int bi, int oi, int md,
                     int hn, int cn, int es);
    @(negedge clk);
    req_valid = 1; base_val = b; off_val = o; base_idx = 4'(bi); off_idx = 4'(oi);
    wb_mode = 2'(md); align_hint = 2'(hn); reg_cnt = 3'(cn); elem_log2 = 2'(es);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_xfer(int wait_cyc);
    for (int i = 0; i < wait_cyc; i++) @(negedge clk);
    xfer_done = 1;
    @(negedge clk);
    xfer_done = 0;
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    cmp("R1 reset outputs", {26'd0, acc_valid, align_fault, illegal, done, wb_en, |acc_addr | |wb_value},
        32'd0);
    rst = 0;
    @(negedge clk);
    cmp("R1 after release", {27'd0, acc_valid, illegal, done, wb_en, |wb_value}, 32'd0);

    // R3: writeback by byte count, four registers, 32-byte hint
    req(32'h0000_1000, 0, 2, 0, 1, 3, 4, 0); finish_xfer(3);
    // R3: wrap modulo 2^32
    req(32'hFFFF_FFF0, 0, 2, 0, 1, 1, 3, 1); finish_xfer(1);
    // R4 + R2: offset writeback wraps, access uses unmodified base
    req(32'hFFFF_FFF8, 32'h10, 3, 5, 2, 1, 1, 0); finish_xfer(2);
    // R5: no writeback
    req(32'h0000_2010, 32'h40, 1, 2, 0, 2, 2, 2); finish_xfer(0);
    // R7: illegal hints for register counts
    req(32'h0000_3000, 0, 1, 0, 1, 2, 3, 0); finish_xfer(1);
    req(32'h0000_3000, 0, 1, 0, 1, 3, 1, 0); finish_xfer(1);
    req(32'h0000_3000, 0, 1, 0, 1, 3, 2, 0); finish_xfer(1);
    // R8 + R11: misaligned for 16-byte hint, later xfer_done gives no done
    req(32'h0000_1008, 0, 1, 0, 1, 2, 2, 0); finish_xfer(1);
    // R9: omitted hint, element alignment
    req(32'h0000_1002, 0, 1, 0, 1, 0, 1, 2); finish_xfer(1);
    req(32'h0000_1003, 0, 1, 0, 1, 0, 1, 0); finish_xfer(1);
    // R10: register index and mode rules
    req(32'h0000_4000, 0, 15, 0, 1, 1, 1, 0); finish_xfer(1);
    req(32'h0000_4000, 4, 1, 13, 2, 1, 1, 0); finish_xfer(1);
    req(32'h0000_4000, 4, 1, 15, 1, 1, 1, 0); finish_xfer(1);
    req(32'h0000_4000, 4, 1, 2, 3, 1, 1, 0); finish_xfer(1);
    req(32'h0000_4000, 4, 1, 2, 1, 1, 0, 0); finish_xfer(1);
    // R7/R8 overlap: illegal and misaligned together
    req(32'h0000_4004, 0, 15, 0, 1, 3, 1, 0); finish_xfer(1);
    // R12: request while busy ignored, xfer_done while idle ignored
    req(32'h0000_5000, 0, 1, 0, 1, 1, 2, 0);
    req(32'h0000_6000, 0, 1, 0, 1, 1, 1, 0);
    finish_xfer(1);
    @(negedge clk); xfer_done = 1; @(negedge clk); xfer_done = 0;
    // R6: new request in the same cycle as the writeback of the previous one
    req(32'h0000_7000, 32'h100, 1, 4, 2, 1, 1, 0);
    @(negedge clk); xfer_done = 1; @(negedge clk); xfer_done = 0;
    req_valid = 1; base_val = 32'h0000_8000; wb_mode = 1; reg_cnt = 2;
    align_hint = 2; base_idx = 1;
    @(negedge clk); req_valid = 0;
    finish_xfer(2);
    // R6: xfer_done held high for several cycles still yields one done
    req(32'h0000_9000, 0, 1, 0, 1, 1, 1, 0);
    xfer_done = 1; repeat (4) @(negedge clk); xfer_done = 0;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles > 200000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected under 200000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule